// File: doc/BRIEF.md
# Multiplexed LCD Refresh Sequencer

This block scans a segment LCD from display memory held on chip. It drives forty outputs. Each output carries a 3-bit drive-level code, and a separate bias network turns that code into a voltage. A programmable multiplex ratio of 2, 4 or 8 decides how many of the lowest outputs act as common (row) lines. The remaining outputs act as column lines. A column-only mode turns all forty outputs into column lines, so that several devices can be cascaded behind one device that drives the rows.

A frame-reference input runs at n times the refresh rate, where n is the active ratio. Each rising edge of the frame-reference moves the scan to the next row. The level of the frame-reference sets the drive polarity, so the DC component across every pixel averages to zero. The display memory holds two banks of eight 40-bit words, and a set bit lights the matching pixel. A requested bank is taken only at the end of a frame, so a frame is never split between two banks. A blank control forces every pixel off, and an all-on control forces every pixel on.

Top module: `lcd_mux_scanner`

## Requirements
- R1: The ratio code `muxSel` selects n rows: 0 gives 2, 1 gives 4, and 2 or 3 give 8. When `colOnly` is low, outputs 0 to n-1 are row lines and outputs n to 39 are column lines. The ratio reaches the outputs one clock after it is applied.
- R2: When `colOnly` is high, all 40 outputs are column lines and none of them carries a row level.
- R3: A rising edge of `frRef`, seen at a clock edge, moves the active row to the next row. After row n-1 the row returns to 0.
- R4: A change of the ratio code sends the row back to 0 on the next clock. This takes precedence over a `frRef` edge in the same cycle.
- R5: The bank shown (`bankReq` sampled) changes only when the row wraps from n-1 to 0.
- R6: Column output k shows bit k of the word at the active row of the active bank. A write (`wrEn`, `wrBank`, `wrAddr`, `wrData`) is visible on the outputs from the next clock.
- R7: Row levels follow the registered `frRef` level (the polarity). With polarity 1, the selected row is at code 4 and an unselected row at code 2. With polarity 0, the selected row is at code 0 and an unselected row at code 1.
- R8: Column levels follow the same polarity. With polarity 1, an on pixel is at code 0 and an off pixel at code 1. With polarity 0, an on pixel is at code 4 and an off pixel at code 2.
- R9: While `blankCmd` is high, every column is driven as off, even when `allOnCmd` is high.
- R10: While `allOnCmd` is high and `blankCmd` is low, every column is driven as on.
- R11: Only the codes 0 (ground), 1 (V1), 2 (V2) and 4 (LCD supply) appear on the outputs.
- R12: After reset the row is 0, the bank is 0, the polarity is 0, the ratio is 2 and both memory banks are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frRef | input | 1 | Frame-reference: rising edge steps the row, level sets polarity |
| muxSel | input | 2 | Multiplex ratio code |
| colOnly | input | 1 | All outputs act as columns |
| bankReq | input | 1 | Bank requested for display |
| blankCmd | input | 1 | Force all pixels off |
| allOnCmd | input | 1 | Force all pixels on |
| wrEn | input | 1 | Display memory write strobe |
| wrBank | input | 1 | Bank written |
| wrAddr | input | 3 | Word (row) written |
| wrData | input | 40 | Word data, bit k for output k |
| segLevel | output | 120 | Level code of output k in bits 3k+2..3k |

## Verification
The bench places a bank request in the middle of a frame. A design that switched banks at once would show a torn frame, and the bench catches this on the column outputs before the wrap. It changes the ratio in the middle of a scan, in the same cycle as a frame-reference edge. A design that let the edge win would leave the row away from 0, or would keep a row past the new count on the row pins. It also combines blank with all-on and with column-only mode, where a wrong priority shows on the column levels. Finally, it writes into the bank being shown during a scan, so a stale read or a wrong bit order appears as a wrong column level in the very next cycle.

// File: rtl/lcdseq_pkg.sv
`timescale 1ns/1ps
package lcdseq_pkg;
  parameter int NUM_PINS = 40;
  parameter int MAX_ROWS = 8;
  parameter int NUM_BANKS = 2;
  parameter int LVL_W = 3;
  localparam int ROW_W = $clog2(MAX_ROWS);
  localparam int CNT_W = ROW_W + 1;

  typedef enum logic [LVL_W-1:0] {
    LVL_GND    = 3'd0,
    LVL_V1     = 3'd1,
    LVL_V2     = 3'd2,
    LVL_V3     = 3'd3,
    LVL_SUPPLY = 3'd4
  } level_e;

  // strobes from the scan control to the drive datapath
  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [CNT_W-1:0] rowCount;
    logic             bank;
    logic             pol;
    logic             colOnly;
  } scanCtl_t;

  function automatic logic [CNT_W-1:0] ratioOf(input logic [1:0] code);
    case (code)
      2'd0:    ratioOf = CNT_W'(2);
      2'd1:    ratioOf = CNT_W'(4);
      default: ratioOf = CNT_W'(MAX_ROWS);
    endcase
  endfunction
endpackage

// File: rtl/lcdseq_ctrl.sv
`timescale 1ns/1ps
module lcdseq_ctrl
  import lcdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frRef,
  input  logic [1:0] muxSel,
  input  logic       colOnly,
  input  logic       bankReq,
  output scanCtl_t   ctl
);
  logic             frQ;
  logic [ROW_W-1:0] rowQ;
  logic             bankQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntReq;
  logic             modeChg;
  logic             frRise;
  logic             rowLast;

  assign cntReq  = ratioOf(muxSel);
  assign modeChg = (cntReq != cntQ);
  assign frRise  = frRef && !frQ;
  assign rowLast = ({1'b0, rowQ} == (cntQ - CNT_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frQ   <= 1'b0;
      rowQ  <= '0;
      bankQ <= 1'b0;
      cntQ  <= CNT_W'(2);
    end else begin
      frQ  <= frRef;
      cntQ <= cntReq;
      if (modeChg) begin
        rowQ <= '0;
      end else if (frRise) begin
        if (rowLast) begin
          rowQ  <= '0;
          bankQ <= bankReq;
        end else begin
          rowQ <= rowQ + ROW_W'(1);
        end
      end
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.row      = rowQ;
    ctl.rowCount = cntQ;
    ctl.bank     = bankQ;
    ctl.pol      = frQ;
    ctl.colOnly  = colOnly;
  end

  assert_row_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, rowQ} < cntQ);
  assert_row_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frRise && !modeChg && rowLast) |=> (rowQ == '0));
  assert_row_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!frRise && !modeChg) |=> $stable(rowQ));
  assert_mode_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (rowQ == '0));
  assert_bank_boundary_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bankQ != $past(bankQ)) |-> (rowQ == '0));
endmodule

// File: rtl/lcdseq_pin_drive.sv
`timescale 1ns/1ps
module lcdseq_pin_drive
  import lcdseq_pkg::*;
#(
  parameter int PIN = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  scanCtl_t         ctl,
  input  logic             pixel,
  input  logic             blank,
  input  logic             allOn,
  output logic [LVL_W-1:0] level
);
  logic isRow;
  logic rowSel;
  logic colOn;

  assign isRow  = !ctl.colOnly && (int'(ctl.rowCount) > PIN);
  assign rowSel = (int'(ctl.row) == PIN);
  assign colOn  = !blank && (allOn || pixel);

  always_comb begin
    if (isRow) begin
      if (ctl.pol) level = rowSel ? LVL_SUPPLY : LVL_V2;
      else         level = rowSel ? LVL_GND    : LVL_V1;
    end else begin
      if (ctl.pol) level = colOn ? LVL_GND    : LVL_V1;
      else         level = colOn ? LVL_SUPPLY : LVL_V2;
    end
  end

  assert_code_legal_R11: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_GND) || (level == LVL_V1) || (level == LVL_V2) || (level == LVL_SUPPLY));
  assert_col_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.colOnly && !ctl.pol) |-> ((level == LVL_SUPPLY) || (level == LVL_V2)));
  assert_blank_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (blank && ctl.colOnly) |-> ((level == LVL_V1) || (level == LVL_V2)));
endmodule

// File: rtl/lcdseq_datapath.sv
`timescale 1ns/1ps
module lcdseq_datapath
  import lcdseq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  scanCtl_t                  ctl,
  input  logic                      blank,
  input  logic                      allOn,
  input  logic                      wrEn,
  input  logic                      wrBank,
  input  logic [ROW_W-1:0]          wrAddr,
  input  logic [NUM_PINS-1:0]       wrData,
  output logic [NUM_PINS*LVL_W-1:0] levels
);
  logic [NUM_PINS-1:0] mem [NUM_BANKS][MAX_ROWS];
  logic [NUM_PINS-1:0] word;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < MAX_ROWS; r++)
          mem[b][r] <= '0;
    end else if (wrEn) begin
      mem[wrBank][wrAddr] <= wrData;
    end
  end

  assign word = mem[ctl.bank][ctl.row];

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    lcdseq_pin_drive #(.PIN(k)) u_drive (
      .clk   (clk),
      .rstN  (rstN),
      .ctl   (ctl),
      .pixel (word[k]),
      .blank (blank),
      .allOn (allOn),
      .level (levels[k*LVL_W +: LVL_W])
    );
  end

  assert_all_on_R10: assert property (@(posedge clk) disable iff (!rstN)
    (allOn && !blank && ctl.colOnly) |->
      (levels[(NUM_PINS-1)*LVL_W +: LVL_W] == (ctl.pol ? LVL_GND : LVL_SUPPLY)));
endmodule

// File: rtl/lcd_mux_scanner.sv
`timescale 1ns/1ps
module lcd_mux_scanner
  import lcdseq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frRef,
  input  logic [1:0]                muxSel,
  input  logic                      colOnly,
  input  logic                      bankReq,
  input  logic                      blankCmd,
  input  logic                      allOnCmd,
  input  logic                      wrEn,
  input  logic                      wrBank,
  input  logic [ROW_W-1:0]          wrAddr,
  input  logic [NUM_PINS-1:0]       wrData,
  output logic [NUM_PINS*LVL_W-1:0] segLevel
);
  scanCtl_t scanCtl;

  lcdseq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frRef   (frRef),
    .muxSel  (muxSel),
    .colOnly (colOnly),
    .bankReq (bankReq),
    .ctl     (scanCtl)
  );

  lcdseq_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (scanCtl),
    .blank  (blankCmd),
    .allOn  (allOnCmd),
    .wrEn   (wrEn),
    .wrBank (wrBank),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .levels (segLevel)
  );
endmodule

// File: tb/lcd_mux_scanner_test.sv
`timescale 1ns/1ps
module lcd_mux_scanner_test;
  localparam int PINS = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, frRef = 1'b0, colOnly = 1'b0, bankReq = 1'b0;
  logic blankCmd = 1'b0, allOnCmd = 1'b0, wrEn = 1'b0, wrBank = 1'b0;
  logic [1:0] muxSel = 2'd0;
  logic [2:0] wrAddr = 3'd0;
  logic [PINS-1:0] wrData = '0;
  logic [PINS*3-1:0] segLevel;

  int checks = 0, errors = 0;
  string curReq = "R12";
  bit done = 1'b0;

  lcd_mux_scanner uut (.*);

  // behavioural reference model
  int mRow = 0, mN = 2;
  bit mBank = 1'b0, mFr = 1'b0;
  logic [PINS-1:0] mMem [2][8];
  initial foreach (mMem[b, r]) mMem[b][r] = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mRow = 0; mN = 2; mBank = 1'b0; mFr = 1'b0;
      foreach (mMem[b, r]) mMem[b][r] = '0;
    end else begin
      int n;
      n = (muxSel == 2'd0) ? 2 : (muxSel == 2'd1) ? 4 : 8;
      if (n != mN) mRow = 0;
      else if (frRef && !mFr) begin
        if (mRow == mN - 1) begin mRow = 0; mBank = bankReq; end
        else mRow = mRow + 1;
      end
      mFr = frRef;
      mN = n;
      if (wrEn) mMem[wrBank][wrAddr] = wrData;
    end
  end

  function automatic int expLevel(int k);
    bit on;
    if (!colOnly && k < mN) begin
      if (k == mRow) return mFr ? 4 : 0;
      return mFr ? 2 : 1;
    end
    on = !blankCmd && (allOnCmd || mMem[mBank][mRow][k]);
    if (mFr) return on ? 0 : 1;
    return on ? 4 : 2;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      int badPin, badGot, badExp;
      bit illegal;
      badPin = -1; badGot = 0; badExp = 0; illegal = 1'b0;
      for (int k = 0; k < PINS; k++) begin
        int g;
        g = int'(segLevel[k*3 +: 3]);
        if (g == 3 || g > 4) illegal = 1'b1;
        if (badPin < 0 && g != expLevel(k)) begin
          badPin = k; badGot = g; badExp = expLevel(k);
        end
      end
      checks++;
      if (badPin >= 0) begin
        errors++;
        $display("FAIL %s pin %0d: got %0d expected %0d at %0t", curReq, badPin, badGot, badExp, $time);
      end
      checks++;
      if (illegal) begin
        errors++;
        $display("FAIL R11 illegal level code: got %h expected codes 0,1,2,4", segLevel);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic frCycle(int hi, int lo);
    frRef = 1'b1;
    repeat (hi) tick();
    frRef = 1'b0;
    repeat (lo) tick();
  endtask

  task automatic checkPin(string tag, int k, int exp);
    int g;
    @(negedge clk);
    #0.1;
    g = int'(segLevel[k*3 +: 3]);
    checks++;
    if (g != exp) begin
      errors++;
      $display("FAIL %s pin %0d: got %0d expected %0d", tag, k, g, exp);
    end
  endtask

  function automatic logic [PINS-1:0] pattern(int b, int r);
    logic [63:0] h;
    h = 64'h9E37_79B9_7F4A_7C15 >> (r * 5 + b * 3);
    return b ? ~h[PINS-1:0] : h[PINS-1:0];
  endfunction

  initial begin
    repeat (3) tick();
    // R12: reset state, ratio 2, polarity 0, row 0, cleared memory
    checkPin("R12", 0, 0);
    checkPin("R12", 1, 1);
    checkPin("R12", 39, 2);
    rstN = 1'b1;
    tick();

    curReq = "R6";
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) begin
        wrEn = 1'b1; wrBank = b[0]; wrAddr = r[2:0]; wrData = pattern(b, r);
        tick();
      end
    wrEn = 1'b0;

    curReq = "R3";
    repeat (6) frCycle(2, 3);
    curReq = "R1";
    muxSel = 2'd1; tick();
    repeat (9) frCycle(3, 2);
    muxSel = 2'd2; repeat (18) frCycle(1, 2);
    muxSel = 2'd3; repeat (5) frCycle(2, 2);

    // R1: ratio 8, rows 0..7 and column at 8, polarity 0
    checkPin("R1", 8, (pattern(0, mRow)[8]) ? 4 : 2);

    curReq = "R4";
    frCycle(1, 1); frCycle(1, 1); frCycle(1, 1);
    frRef = 1'b1; muxSel = 2'd0; tick();
    frRef = 1'b0; repeat (2) tick();
    checkPin("R4", 0, 0);
    repeat (4) frCycle(2, 2);
    muxSel = 2'd1; tick();
    frCycle(2, 2);

    curReq = "R5";
    bankReq = 1'b1;
    repeat (10) frCycle(2, 2);
    bankReq = 1'b0;
    frCycle(2, 2);
    repeat (6) frCycle(2, 2);

    curReq = "R6";
    frRef = 1'b1; tick();
    wrEn = 1'b1; wrBank = mBank; wrAddr = mRow[2:0]; wrData = 40'hF0_0F_55_AA_C3;
    tick(); wrEn = 1'b0;
    repeat (2) tick();
    frRef = 1'b0; tick();

    curReq = "R7";
    frRef = 1'b1; repeat (4) tick();
    curReq = "R8";
    frRef = 1'b0; repeat (4) tick();

    curReq = "R2";
    colOnly = 1'b1;
    repeat (6) frCycle(2, 2);

    curReq = "R9";
    blankCmd = 1'b1;
    frCycle(2, 2);
    checkPin("R9", 39, 2);
    allOnCmd = 1'b1;
    frCycle(2, 2);
    checkPin("R9", 20, 2);
    colOnly = 1'b0;
    frCycle(2, 2);
    blankCmd = 1'b0;

    curReq = "R10";
    frCycle(2, 2);
    checkPin("R10", 39, 4);
    frRef = 1'b1; tick();
    checkPin("R10", 39, 0);
    frRef = 1'b0; tick();
    colOnly = 1'b1;
    repeat (3) frCycle(2, 2);
    allOnCmd = 1'b0;
    curReq = "R8";
    repeat (3) frCycle(2, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule